// File: doc/BRIEF.md
# Descriptor-Chained DMA Controller

This block moves bytes between memory locations for many independent channels. Channels do not own their transfer settings. Each one points into a shared pool of transaction descriptors. A descriptor holds a source address, a destination address, a byte count, a successor index and a few control bits. When a descriptor's count runs out, the channel either moves on to the successor or stops. A descriptor that names itself repeats forever, which suits sending a fixed pattern to a peripheral. Two descriptors that name each other give a ping-pong buffer scheme. Software may rewrite any descriptor while the engine runs.

A single engine serves one byte at a time. A byte is a read cycle followed by a write cycle on a simple synchronous memory port. Before every byte, the engine picks a winner among the channels that are enabled and requesting. The highest priority level wins, and channels that share a level take turns. Each channel has a completion output that pulses for one cycle when a descriptor finishes and a completion is due.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, all channels are disabled, `mem_en` is 0 and `ch_done` is 0. No transfer starts, whatever the request inputs are doing.
- R2: A configuration write with `cfg_chan`=1 programs channel `cfg_idx` from a single data word. Bits [6:0] give the first descriptor, bits [9:7] the priority and bit 10 the enable. The channel starts from that descriptor with its settings freshly loaded. Each byte is a read cycle at the source address (`mem_en`=1, `mem_we`=0). It is followed in the next cycle by a write cycle at the destination address (`mem_we`=1), which carries the byte returned by the read.
- R3: A descriptor is written with `cfg_chan`=0 and `cfg_idx` = its index. The field is chosen by `cfg_fld`: 0 = source, 1 = destination, 2 = byte count, 3 = control. Control bits [6:0] give the successor index, bit 7 enables chaining, bit 8 steps the source address, bit 9 steps the destination address and bit 10 enables completion. A set step bit moves that address up by 1 per byte; a clear step bit keeps it fixed.
- R4: A descriptor with count N moves exactly N bytes. A count of 0 moves no bytes, and the descriptor finishes at once.
- R5: When a descriptor finishes with chaining enabled, the channel continues with the successor descriptor. With chaining clear, the channel disables itself and makes no further transfers until it is programmed again.
- R6: When a descriptor finishes, the channel's `ch_done` bit is high for exactly one cycle if the completion bit is set or the chaining bit is clear. It stays low otherwise. At most one `ch_done` bit is high in any cycle.
- R7: A descriptor that names itself as successor repeats its transfer until a channel write clears the enable bit. Transfers then stop.
- R8: Two descriptors that name each other alternate without end. With their completion bits set, `ch_done` pulses at the end of each one.
- R9: Among pending channels, a channel with a higher priority value is always granted before one with a lower value.
- R10: Pending channels that share the highest pending level are granted one byte each in rotating order.
- R11: A descriptor rewritten while in use takes effect the next time it is loaded. A pass already under way finishes with the values it loaded.
- R12: A channel whose request input is low is not served, and its progress is held until the request returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 1 | 1 = channel write, 0 = descriptor write |
| cfg_idx | input | 7 | Channel or descriptor index |
| cfg_fld | input | 2 | Descriptor field select |
| cfg_wdata | input | 16 | Configuration write data |
| ch_req | input | 24 | Per-channel transfer request (level) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| ch_done | output | 24 | Per-channel completion pulse |

## Verification
The collision that matters is a software rewrite of a descriptor landing in the same cycle, or the same pass, in which the engine loads or works through that descriptor. The bench provokes it by running a self-repeating descriptor and flipping its source address many times at random intervals. Every complete pass seen on the write port is then judged: it must be wholly the old pattern or wholly the new one, and at least one pass must show the new source. A second overlap is arbitration meeting chaining and completion. Equal and unequal priorities are raised in the same cycle, and the interleaving of the write log is compared against the expected order.

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int NCH   = 24,
  parameter int NDESC = 128,
  parameter int AW    = 16,
  parameter int CW    = 12,
  parameter int PW    = 3,
  localparam int CHW  = $clog2(NCH),
  localparam int DIW  = $clog2(NDESC),
  localparam int IW   = (DIW > CHW) ? DIW : CHW,
  localparam int X1   = (AW > CW) ? AW : CW,
  localparam int X2   = (DIW + 4 > DIW + PW + 1) ? DIW + 4 : DIW + PW + 1,
  localparam int XW   = (X1 > X2) ? X1 : X2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_chan,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_fld,
  input  logic [XW-1:0] cfg_wdata,
  input  logic [NCH-1:0] ch_req,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [NCH-1:0] ch_done
);

  localparam int B_CHAIN = DIW;
  localparam int B_SINC  = DIW + 1;
  localparam int B_DINC  = DIW + 2;
  localparam int B_IRQ   = DIW + 3;
  localparam int B_EN    = DIW + PW;

  typedef enum logic [1:0] {S_ARB, S_LOAD, S_RD, S_WR} state_t;

  logic [AW-1:0]  p_src [NDESC];
  logic [AW-1:0]  p_dst [NDESC];
  logic [CW-1:0]  p_cnt [NDESC];
  logic [DIW+3:0] p_ctl [NDESC];

  logic [NCH-1:0] ch_en, ch_ld, done_q;
  logic [PW-1:0]  ch_pri  [NCH];
  logic [DIW-1:0] ch_desc [NCH];
  logic [AW-1:0]  ch_src  [NCH];
  logic [AW-1:0]  ch_dst  [NCH];
  logic [CW-1:0]  ch_rem  [NCH];
  logic [DIW+3:0] ch_ctl  [NCH];

  state_t         st;
  logic [CHW-1:0] cur, last, win;
  logic [PW-1:0]  maxp;
  logic [NCH-1:0] pend;
  logic           any, fin;
  logic [DIW+3:0] fin_ctl;
  logic [DIW-1:0] cd;

  wire desc_wr = cfg_we && !cfg_chan && (int'(cfg_idx) < NDESC);
  wire chan_wr = cfg_we &&  cfg_chan && (int'(cfg_idx) < NCH);

  assign pend = ch_en & ch_req;
  assign any  = |pend;
  assign cd   = ch_desc[cur];

  always_comb begin
    maxp = '0;
    for (int i = 0; i < NCH; i++)
      if (pend[i] && ch_pri[i] > maxp) maxp = ch_pri[i];
  end

  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = int'(last) + k;
      if (j >= NCH) j = j - NCH;
      if (!found && pend[j] && ch_pri[j] == maxp) begin
        win   = CHW'(j);
        found = 1'b1;
      end
    end
  end

  assign fin_ctl = (st == S_LOAD) ? p_ctl[cd] : ch_ctl[cur];
  assign fin     = (st == S_LOAD && p_cnt[cd] == '0) ||
                   (st == S_WR && ch_rem[cur] == CW'(1));

  assign mem_en    = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? ch_dst[cur] : ch_src[cur];
  assign mem_wdata = mem_rdata;
  assign ch_done   = done_q;

  always_ff @(posedge clk) begin
    if (desc_wr) begin
      case (cfg_fld)
        2'd0: p_src[cfg_idx[DIW-1:0]] <= cfg_wdata[AW-1:0];
        2'd1: p_dst[cfg_idx[DIW-1:0]] <= cfg_wdata[AW-1:0];
        2'd2: p_cnt[cfg_idx[DIW-1:0]] <= cfg_wdata[CW-1:0];
        default: p_ctl[cfg_idx[DIW-1:0]] <= cfg_wdata[DIW+3:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_ARB;
      cur    <= '0;
      last   <= CHW'(NCH - 1);
      done_q <= '0;
      ch_en  <= '0;
      ch_ld  <= '0;
      for (int i = 0; i < NCH; i++) begin
        ch_pri[i]  <= '0;
        ch_desc[i] <= '0;
        ch_src[i]  <= '0;
        ch_dst[i]  <= '0;
        ch_rem[i]  <= '0;
        ch_ctl[i]  <= '0;
      end
    end else begin
      done_q <= '0;
      case (st)
        S_ARB: if (any) begin
          cur  <= win;
          last <= win;
          st   <= ch_ld[win] ? S_RD : S_LOAD;
        end
        S_LOAD: begin
          ch_src[cur] <= p_src[cd];
          ch_dst[cur] <= p_dst[cd];
          ch_rem[cur] <= p_cnt[cd];
          ch_ctl[cur] <= p_ctl[cd];
          ch_ld[cur]  <= 1'b1;
          st <= (p_cnt[cd] == '0) ? S_ARB : S_RD;
        end
        S_RD: st <= S_WR;
        default: begin
          ch_src[cur] <= ch_src[cur] + AW'(ch_ctl[cur][B_SINC]);
          ch_dst[cur] <= ch_dst[cur] + AW'(ch_ctl[cur][B_DINC]);
          ch_rem[cur] <= ch_rem[cur] - CW'(1);
          st <= S_ARB;
        end
      endcase
      if (fin) begin
        ch_ld[cur] <= 1'b0;
        if (fin_ctl[B_CHAIN]) ch_desc[cur] <= fin_ctl[DIW-1:0];
        else                  ch_en[cur]   <= 1'b0;
        done_q[cur] <= fin_ctl[B_IRQ] | ~fin_ctl[B_CHAIN];
      end
      if (chan_wr) begin
        ch_en[cfg_idx[CHW-1:0]]   <= cfg_wdata[B_EN];
        ch_pri[cfg_idx[CHW-1:0]]  <= cfg_wdata[DIW+PW-1:DIW];
        ch_desc[cfg_idx[CHW-1:0]] <= cfg_wdata[DIW-1:0];
        ch_ld[cfg_idx[CHW-1:0]]   <= 1'b0;
      end
    end
  end

  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_done)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (|ch_done) |=> !(|ch_done)); // R6
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) (mem_en && mem_we) |-> $past(mem_en && !mem_we)); // R2
  AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (mem_en && !mem_we) |-> (ch_rem[cur] != '0)); // R4
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) (st == S_ARB && !any) |=> !mem_en); // R12

  always_ff @(posedge clk) begin
    if (rst_n && st == S_ARB && any)
      for (int i = 0; i < NCH; i++)
        if (pend[i]) AST_PRIO_ORDER: assert (ch_pri[i] <= ch_pri[win]); // R9
  end

endmodule

// File: tb/dma_chain_ctrl_bench.sv
module dma_chain_ctrl_bench;
  localparam int NCH = 24;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_chan = 0;
  logic [6:0]  cfg_idx = '0;
  logic [1:0]  cfg_fld = '0;
  logic [15:0] cfg_wdata = '0;
  logic [NCH-1:0] ch_req = '0;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic [NCH-1:0] ch_done;

  dma_chain_ctrl u_dma_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_idx(cfg_idx), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
    .ch_req(ch_req), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ch_done(ch_done));

  always #2 clk = ~clk;

  int ncmp = 0, nfail = 0, cyc = 0;
  int lcnt = 0, dbl = 0;
  int dcnt [NCH];
  logic [15:0] laddr [8192];
  logic [7:0]  ldata [8192];
  logic [NCH-1:0] dprev = '0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ {a[11:8], a[11:8]};
  endfunction

  always @(posedge clk) mem_rdata <= pat(mem_addr);

  initial for (int c = 0; c < NCH; c++) dcnt[c] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we) begin
        laddr[lcnt] = mem_addr;
        ldata[lcnt] = mem_wdata;
        lcnt++;
      end
      for (int c = 0; c < NCH; c++) if (ch_done[c]) dcnt[c]++;
      if ((ch_done & dprev) != '0) dbl++;
      dprev = ch_done;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input bit ch, input int idx, input int fld, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_chan = ch; cfg_idx = 7'(idx); cfg_fld = 2'(fld); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic desc(input int idx, input int src, input int dst, input int cnt,
                      input int nxt, input int chain, input int si, input int di, input int irq);
    cfg(0, idx, 0, src);
    cfg(0, idx, 1, dst);
    cfg(0, idx, 2, cnt);
    cfg(0, idx, 3, nxt | (chain << 7) | (si << 8) | (di << 9) | (irq << 10));
  endtask

  task automatic chan(input int c, input int en, input int pri, input int first);
    cfg(1, c, 0, first | (pri << 7) | (en << 10));
  endtask

  task automatic wait_done(input int c, input int n);
    int t = 0;
    while (dcnt[c] < n && t < 20000) begin @(posedge clk); t++; end
    if (t >= 20000) chk(0, "timeout waiting for completion", dcnt[c], n);
  endtask

  task automatic check_copy(input string tag, input int base, input int n,
                            input int src, input int dst, input int si, input int di);
    for (int k = 0; k < n; k++) begin
      chk(laddr[base+k] == 16'(dst + k*di), {tag, " address"}, int'(laddr[base+k]), dst + k*di);
      chk(ldata[base+k] == pat(16'(src + k*si)), {tag, " data"}, int'(ldata[base+k]), int'(pat(16'(src + k*si))));
    end
  endtask

  initial begin
    int b, s, n, g, seenb, ok, t0, t1;
    void'($urandom(32'd1234));

    // R1 reset state
    repeat (5) @(negedge clk);
    chk(mem_en == 0, "R1 mem_en in reset", int'(mem_en), 0);
    chk(ch_done == 0, "R1 ch_done in reset", int'(ch_done), 0);
    rst_n = 1;
    ch_req = '1;
    repeat (30) @(negedge clk);
    chk(lcnt == 0, "R1 no transfer while disabled", lcnt, 0);
    chk(ch_done == 0, "R1 no completion while disabled", int'(ch_done), 0);
    ch_req = '0;

    // R2 R5 R6 plain copy, no chaining
    desc(0, 'h100, 'h200, 8, 0, 0, 1, 1, 0);
    b = lcnt;
    chan(0, 1, 0, 0);
    ch_req[0] = 1;
    wait_done(0, 1);
    repeat (40) @(negedge clk);
    chk(lcnt - b == 8, "R2 byte count of copy", lcnt - b, 8);
    check_copy("R2 copy", b, 8, 'h100, 'h200, 1, 1);
    chk(dcnt[0] == 1, "R6 one completion at chain end", dcnt[0], 1);
    chk(lcnt - b == 8, "R5 channel stays disabled", lcnt - b, 8);
    ch_req[0] = 0;

    // R3 fixed destination, then fixed source
    desc(1, 'h140, 'h600, 5, 0, 0, 1, 0, 0);
    b = lcnt; chan(1, 1, 0, 1); ch_req[1] = 1;
    wait_done(1, 1); repeat (10) @(negedge clk); ch_req[1] = 0;
    chk(lcnt - b == 5, "R3 count fixed dst", lcnt - b, 5);
    check_copy("R3 fixed dst", b, 5, 'h140, 'h600, 1, 0);
    desc(2, 'h180, 'h640, 5, 0, 0, 0, 1, 0);
    b = lcnt; chan(2, 1, 0, 2); ch_req[2] = 1;
    wait_done(2, 1); repeat (10) @(negedge clk); ch_req[2] = 0;
    chk(lcnt - b == 5, "R3 count fixed src", lcnt - b, 5);
    check_copy("R3 fixed src", b, 5, 'h180, 'h640, 0, 1);

    // R4 zero count
    desc(3, 'h1C0, 'h680, 0, 0, 0, 1, 1, 0);
    b = lcnt; chan(3, 1, 0, 3); ch_req[3] = 1;
    wait_done(3, 1); repeat (20) @(negedge clk); ch_req[3] = 0;
    chk(lcnt == b, "R4 zero count moves nothing", lcnt - b, 0);
    chk(dcnt[3] == 1, "R4 zero count completes", dcnt[3], 1);

    // R5 chain of two descriptors, completion only at the end
    desc(10, 'h200, 'h700, 3, 11, 1, 1, 1, 0);
    desc(11, 'h240, 'h720, 4, 0, 0, 1, 1, 0);
    b = lcnt; chan(4, 1, 1, 10); ch_req[4] = 1;
    wait_done(4, 1); repeat (20) @(negedge clk); ch_req[4] = 0;
    chk(lcnt - b == 7, "R5 chained byte total", lcnt - b, 7);
    check_copy("R5 first link", b, 3, 'h200, 'h700, 1, 1);
    check_copy("R5 second link", b + 3, 4, 'h240, 'h720, 1, 1);
    chk(dcnt[4] == 1, "R6 no completion mid chain", dcnt[4], 1);

    // R8 ping-pong
    desc(20, 'h300, 'h780, 4, 21, 1, 1, 1, 1);
    desc(21, 'h340, 'h7C0, 4, 20, 1, 1, 1, 1);
    b = lcnt; chan(5, 1, 2, 20); ch_req[5] = 1;
    wait_done(5, 4);
    chan(5, 0, 2, 20); ch_req[5] = 0;
    repeat (20) @(negedge clk);
    n = lcnt - b;
    chk(n >= 16, "R8 ping-pong bytes", n, 16);
    for (int q = 0; q < 16; q++) begin
      s = ((q / 4) % 2 == 0) ? 'h780 : 'h7C0;
      chk(laddr[b+q] == 16'(s + q % 4), "R8 alternating buffers", int'(laddr[b+q]), s + q % 4);
    end
    chk(dcnt[5] >= 4, "R8 completion per descriptor", dcnt[5], 4);
    s = lcnt; repeat (30) @(negedge clk);
    chk(lcnt == s, "R7 disable stops ping-pong", lcnt - s, 0);

    // R7 R11 auto-repeat with random rewrites of the source
    desc(30, 'h400, 'h7F0, 4, 30, 1, 1, 0, 0);
    b = lcnt; chan(6, 1, 3, 30); ch_req[6] = 1;
    for (int it = 0; it < 40; it++) begin
      repeat ($urandom % 13 + 1) @(negedge clk);
      cfg(0, 30, 0, (it % 2 == 0) ? 'h500 : 'h400);
    end
    chan(6, 0, 3, 30); ch_req[6] = 0;
    repeat (20) @(negedge clk);
    s = lcnt; repeat (20) @(negedge clk);
    chk(lcnt == s, "R7 repeat stops after disable", lcnt - s, 0);
    n = (s - b) / 4;
    chk(n >= 10, "R7 repeat passes", n, 10);
    seenb = 0;
    for (int q = 0; q < n; q++) begin
      t0 = 1; t1 = 1;
      for (int k = 0; k < 4; k++) begin
        if (laddr[b+4*q+k] != 16'h7F0) begin t0 = 0; t1 = 0; end
        if (ldata[b+4*q+k] != pat(16'('h400 + k))) t0 = 0;
        if (ldata[b+4*q+k] != pat(16'('h500 + k))) t1 = 0;
      end
      chk(t0 == 1 || t1 == 1, "R11 pass uses one descriptor value", q, -1);
      if (t1 == 1) seenb++;
    end
    chk(seenb > 0, "R11 rewrite takes effect", seenb, 1);

    // R9 priority
    desc(40, 'h600, 'h900, 6, 0, 0, 1, 1, 0);
    desc(41, 'h640, 'h940, 6, 0, 0, 1, 1, 0);
    chan(7, 1, 2, 40); chan(8, 1, 5, 41);
    b = lcnt;
    ch_req[7] = 1; ch_req[8] = 1;
    wait_done(7, 1); wait_done(8, 1);
    repeat (10) @(negedge clk); ch_req[7] = 0; ch_req[8] = 0;
    chk(lcnt - b == 12, "R9 total bytes", lcnt - b, 12);
    check_copy("R9 high level first", b, 6, 'h640, 'h940, 1, 1);
    check_copy("R9 low level after", b + 6, 6, 'h600, 'h900, 1, 1);

    // R10 round robin on equal level
    desc(42, 'h680, 'h980, 3, 0, 0, 1, 1, 0);
    desc(43, 'h6C0, 'h9C0, 3, 0, 0, 1, 1, 0);
    desc(44, 'h700, 'hA00, 3, 0, 0, 1, 1, 0);
    chan(9, 1, 4, 42); chan(10, 1, 4, 43); chan(11, 1, 4, 44);
    b = lcnt;
    ch_req[11:9] = 3'b111;
    wait_done(9, 1); wait_done(10, 1); wait_done(11, 1);
    repeat (10) @(negedge clk); ch_req[11:9] = 3'b000;
    chk(lcnt - b == 9, "R10 total bytes", lcnt - b, 9);
    for (int q = 0; q < 9; q++) begin
      g = q / 3;
      s = (int'(laddr[b+q]) - 'h980) >> 6;
      n = (int'(laddr[b+(q%3)]) - 'h980) >> 6;
      chk(s == n, "R10 rotating order", s, n);
      chk(laddr[b+q] == 16'('h980 + 64*s + g), "R10 one byte per turn", int'(laddr[b+q]), 'h980 + 64*s + g);
      chk(ldata[b+q] == pat(16'('h680 + 64*s + g)), "R10 data", int'(ldata[b+q]), int'(pat(16'('h680 + 64*s + g))));
    end
    ok = (laddr[b] != laddr[b+1]) && (laddr[b] != laddr[b+2]) && (laddr[b+1] != laddr[b+2]);
    chk(ok == 1, "R10 all three channels in a turn", ok, 1);

    // R12 request low holds the channel
    desc(45, 'h740, 'hA40, 4, 0, 0, 1, 1, 0);
    b = lcnt; chan(12, 1, 1, 45);
    repeat (100) @(negedge clk);
    chk(lcnt == b, "R12 no transfer while request low", lcnt - b, 0);
    chk(dcnt[12] == 0, "R12 no completion while request low", dcnt[12], 0);
    ch_req[12] = 1;
    wait_done(12, 1); repeat (10) @(negedge clk); ch_req[12] = 0;
    chk(lcnt - b == 4, "R12 transfer after request", lcnt - b, 4);
    check_copy("R12 copy", b, 4, 'h740, 'hA40, 1, 1);

    // random single-channel transfers, R2 R3 R4
    for (int i = 0; i < 10; i++) begin
      int c, src, dst, cnt, si, di, pri, tgt;
      c = 13 + (i % 8);
      src = $urandom % 'h800; dst = 'hB00 + i * 16;
      cnt = $urandom % 13; si = $urandom % 2; di = $urandom % 2; pri = $urandom % 8;
      desc(50 + i, src, dst, cnt, 0, 0, si, di, $urandom % 2);
      tgt = dcnt[c] + 1;
      b = lcnt; chan(c, 1, pri, 50 + i); ch_req[c] = 1;
      wait_done(c, tgt); repeat (10) @(negedge clk); ch_req[c] = 0;
      chk(lcnt - b == cnt, "R4 random count", lcnt - b, cnt);
      check_copy("R3 random copy", b, cnt, src, dst, si, di);
      chk(dcnt[c] == tgt, "R6 random completion", dcnt[c], tgt);
    end

    chk(dbl == 0, "R6 completion lasts one cycle", dbl, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule